// File: doc/BRIEF.md
# Register Dependency Matrix with Latest-Writer Renaming

This block tracks register hazards between a set of function units and the architectural register file. It keeps one row per function unit and one column per register. A row records which registers the unit still has to read and which one it will write. Alongside these flags, every column holds a single "latest writer" flag. That flag marks the one unit whose pending result is the newest value of the register. Renaming therefore happens inside the matrix itself: there is no alias table, no tag compare and no separate physical register file.

The issue stage presents one instruction per cycle. It gives the unit that will run the instruction, an optional destination register and up to two source registers. In the same clock edge the block does three things. It rewrites the issuing unit's row. It moves the destination's latest-writer flag to that row. For each source it looks up the unit that holds the flag, and that unit becomes a producer the new instruction has to wait for. The producer vectors, one per unit, are kept and updated as units finish. The per-register pending-read, pending-write and renamed wires go to the register file and the operand-forwarding logic. Data values are not stored here.

Top module: `regdep_matrix`

## Requirements
- R1: Reset (rst_n low) clears every need-read, need-write, latest-writer and producer bit, so that rd_pend, wr_pend, rn_held and prod_vec all read zero.
- R2: An issue sets, in the issuing unit's row, a need-read bit for each source whose valid bit is set and a need-write bit for the destination when iss_has_dst is 1. The bits show on rd_pend and wr_pend in the cycle after the issue edge.
- R3: A register column never holds more than one latest-writer bit. An issue with a destination clears any existing latest-writer bit in that column and sets it in the issuing unit's row.
- R4: After an issue, bit f of prod_vec[u] (u being the issuing unit) is 1 when some valid source register had its latest-writer bit held by unit f. The result is the OR over both sources.
- R5: Once the latest-writer bit of a register has moved, later readers of that register get a producer bit for the new writer only.
- R6: rd_pend[r] is 1 when any unit still needs to read r. wr_pend[r] is 1 when any unit still has to write r. rn_held[r] is 1 when some unit holds the latest-writer bit of r. A register can be write-pending without being renamed.
- R7: wr_done[f] clears the need-write bits of unit f. It clears a latest-writer bit only where unit f still holds it, and it clears bit f of every producer vector.
- R8: A source register whose latest-writer bit is held by no unit adds no producer bit; the operand is taken from the register file.
- R9: rd_done[f] clears all need-read bits of unit f and leaves other units' bits alone.
- R10: Lookups use the state before the issue edge. A source equal to the instruction's own destination depends on the previous writer, never on the issuing unit. A holder that asserts wr_done in the issue cycle adds no producer bit.
- R11: An issue replaces the issuing unit's whole row, so need-read bits left from the unit's earlier instruction are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_fu | input | 3 | Index of the issuing function unit |
| iss_has_dst | input | 1 | Instruction writes a destination register |
| iss_dst | input | 5 | Destination register index |
| iss_src_vld | input | 2 | Per-source valid bits |
| iss_src | input | 2x5 | Source register indices, source s at [s] |
| rd_done | input | 8 | Per-unit: operands have been read |
| wr_done | input | 8 | Per-unit: result written to the register file |
| prod_vec | output | 8x8 | prod_vec[u][f]: unit u waits on a result of unit f |
| rd_pend | output | 32 | Per-register: some unit needs to read it |
| wr_pend | output | 32 | Per-register: some unit still has to write it |
| rn_held | output | 32 | Per-register: some unit holds the latest-writer bit |

## Verification
A table of eight back-to-back issues with no completions exercises the lookup. The entries cover sources with no holder, a single producer, two different producers, both sources naming the same register, and a source equal to its own destination. They also re-read a register after its writer was replaced, which separates "newest writer" from "any pending writer". Directed steps then retire units one at a time. Retiring the holder of a register shows that rn_held drops while wr_pend stays up for an older writer. Retiring a superseded writer shows that it leaves the current holder in place. Further steps retire a holder in the very cycle a reader issues, clear read flags, reissue a unit over its old row, and pulse reset partway through the run.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  localparam int unsigned DEF_FU_N  = 8;
  localparam int unsigned DEF_REG_N = 32;
  localparam int unsigned DEF_SRC_N = 2;
endpackage

// File: rtl/rdm_fu_row.sv
module rdm_fu_row #(
  parameter int unsigned REG_N = rdm_pkg::DEF_REG_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_me,
  input  logic             iss_any,
  input  logic             iss_has_dst,
  input  logic [REG_N-1:0] iss_dst_oh,
  input  logic [REG_N-1:0] iss_rd_oh,
  input  logic             rd_done,
  input  logic             wr_done,
  output logic [REG_N-1:0] need_rd,
  output logic [REG_N-1:0] need_wr,
  output logic [REG_N-1:0] latest
);
  // column claimed by any issuing unit this cycle
  logic [REG_N-1:0] claim;
  logic [REG_N-1:0] own_dst;

  assign own_dst = iss_has_dst ? iss_dst_oh : '0;
  assign claim   = (iss_any && iss_has_dst) ? iss_dst_oh : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_rd <= '0;
      need_wr <= '0;
      latest  <= '0;
    end else if (iss_me) begin
      need_rd <= iss_rd_oh;
      need_wr <= own_dst;
      latest  <= own_dst;
    end else begin
      if (rd_done) need_rd <= '0;
      if (wr_done) begin
        need_wr <= '0;
        latest  <= '0;
      end else begin
        latest <= latest & ~claim;
      end
    end
  end
endmodule

// File: rtl/rdm_src_lookup.sv
module rdm_src_lookup #(
  parameter int unsigned FU_N  = rdm_pkg::DEF_FU_N,
  parameter int unsigned REG_N = rdm_pkg::DEF_REG_N,
  localparam int unsigned RW   = $clog2(REG_N)
) (
  input  logic                       src_vld,
  input  logic [RW-1:0]              src_idx,
  input  logic [FU_N-1:0][REG_N-1:0] lat_m,
  input  logic [FU_N-1:0]            wr_done,
  output logic [FU_N-1:0]            holder
);
  function automatic logic [FU_N-1:0] column_of(
    input logic [FU_N-1:0][REG_N-1:0] m, input logic [RW-1:0] r);
    logic [FU_N-1:0] c;
    for (int f = 0; f < FU_N; f++) c[f] = m[f][r];
    return c;
  endfunction

  always_comb begin
    holder = '0;
    if (src_vld) holder = column_of(lat_m, src_idx) & ~wr_done;
  end
endmodule

// File: rtl/rdm_prod_store.sv
module rdm_prod_store #(
  parameter int unsigned FU_N  = rdm_pkg::DEF_FU_N,
  parameter int unsigned SRC_N = rdm_pkg::DEF_SRC_N,
  localparam int unsigned FW   = $clog2(FU_N)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_valid,
  input  logic [FW-1:0]             iss_fu,
  input  logic [SRC_N-1:0][FU_N-1:0] holders,
  input  logic [FU_N-1:0]           wr_done,
  output logic [FU_N-1:0][FU_N-1:0] prod
);
  function automatic logic [FU_N-1:0] merge(
    input logic [SRC_N-1:0][FU_N-1:0] h);
    logic [FU_N-1:0] acc;
    acc = '0;
    for (int s = 0; s < SRC_N; s++) acc = acc | h[s];
    return acc;
  endfunction

  logic [FU_N-1:0] new_row;
  assign new_row = merge(holders);

  for (genvar u = 0; u < FU_N; u++) begin : g_row
    logic load;
    assign load = iss_valid && (iss_fu == FW'(u));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prod[u] <= '0;
      else if (load) prod[u] <= new_row;
      else           prod[u] <= prod[u] & ~wr_done;
    end
  end
endmodule

// File: rtl/rdm_pend_reduce.sv
module rdm_pend_reduce #(
  parameter int unsigned FU_N  = rdm_pkg::DEF_FU_N,
  parameter int unsigned REG_N = rdm_pkg::DEF_REG_N
) (
  input  logic [FU_N-1:0][REG_N-1:0] rd_m,
  input  logic [FU_N-1:0][REG_N-1:0] wr_m,
  input  logic [FU_N-1:0][REG_N-1:0] lat_m,
  output logic [REG_N-1:0]           rd_pend,
  output logic [REG_N-1:0]           wr_pend,
  output logic [REG_N-1:0]           rn_held
);
  function automatic logic [REG_N-1:0] fold_rows(
    input logic [FU_N-1:0][REG_N-1:0] m);
    logic [REG_N-1:0] acc;
    acc = '0;
    for (int f = 0; f < FU_N; f++) acc = acc | m[f];
    return acc;
  endfunction

  assign rd_pend = fold_rows(rd_m);
  assign wr_pend = fold_rows(wr_m);
  assign rn_held = fold_rows(lat_m);
endmodule

// File: rtl/regdep_matrix.sv
module regdep_matrix #(
  parameter int unsigned FU_N  = rdm_pkg::DEF_FU_N,
  parameter int unsigned REG_N = rdm_pkg::DEF_REG_N,
  parameter int unsigned SRC_N = rdm_pkg::DEF_SRC_N,
  localparam int unsigned FW   = $clog2(FU_N),
  localparam int unsigned RW   = $clog2(REG_N)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       iss_valid,
  input  logic [FW-1:0]              iss_fu,
  input  logic                       iss_has_dst,
  input  logic [RW-1:0]              iss_dst,
  input  logic [SRC_N-1:0]           iss_src_vld,
  input  logic [SRC_N-1:0][RW-1:0]   iss_src,
  input  logic [FU_N-1:0]            rd_done,
  input  logic [FU_N-1:0]            wr_done,
  output logic [FU_N-1:0][FU_N-1:0]  prod_vec,
  output logic [REG_N-1:0]           rd_pend,
  output logic [REG_N-1:0]           wr_pend,
  output logic [REG_N-1:0]           rn_held
);
  function automatic logic [REG_N-1:0] idx_to_oh(input logic [RW-1:0] i);
    logic [REG_N-1:0] v;
    v = '0;
    v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [REG_N-1:0] reads_oh(
    input logic [SRC_N-1:0] vld, input logic [SRC_N-1:0][RW-1:0] idx);
    logic [REG_N-1:0] v;
    v = '0;
    for (int s = 0; s < SRC_N; s++) if (vld[s]) v = v | idx_to_oh(idx[s]);
    return v;
  endfunction

  // named internal events, also seen by the checker
  logic [REG_N-1:0]             iss_dst_oh;
  logic [REG_N-1:0]             iss_rd_oh;
  logic [FU_N-1:0][REG_N-1:0]   rd_m;
  logic [FU_N-1:0][REG_N-1:0]   wr_m;
  logic [FU_N-1:0][REG_N-1:0]   lat_m;
  logic [SRC_N-1:0][FU_N-1:0]   holders;

  assign iss_dst_oh = idx_to_oh(iss_dst);
  assign iss_rd_oh  = reads_oh(iss_src_vld, iss_src);

  for (genvar f = 0; f < FU_N; f++) begin : g_fu
    logic iss_me;
    assign iss_me = iss_valid && (iss_fu == FW'(f));
    rdm_fu_row #(.REG_N(REG_N)) u_row (
      .clk        (clk),
      .rst_n      (rst_n),
      .iss_me     (iss_me),
      .iss_any    (iss_valid),
      .iss_has_dst(iss_has_dst),
      .iss_dst_oh (iss_dst_oh),
      .iss_rd_oh  (iss_rd_oh),
      .rd_done    (rd_done[f]),
      .wr_done    (wr_done[f]),
      .need_rd    (rd_m[f]),
      .need_wr    (wr_m[f]),
      .latest     (lat_m[f])
    );
  end

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    rdm_src_lookup #(.FU_N(FU_N), .REG_N(REG_N)) u_lookup (
      .src_vld(iss_src_vld[s]),
      .src_idx(iss_src[s]),
      .lat_m  (lat_m),
      .wr_done(wr_done),
      .holder (holders[s])
    );
  end

  rdm_prod_store #(.FU_N(FU_N), .SRC_N(SRC_N)) u_prod (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_valid(iss_valid),
    .iss_fu   (iss_fu),
    .holders  (holders),
    .wr_done  (wr_done),
    .prod     (prod_vec)
  );

  rdm_pend_reduce #(.FU_N(FU_N), .REG_N(REG_N)) u_pend (
    .rd_m   (rd_m),
    .wr_m   (wr_m),
    .lat_m  (lat_m),
    .rd_pend(rd_pend),
    .wr_pend(wr_pend),
    .rn_held(rn_held)
  );
endmodule

// File: rtl/rdm_chk.sv
module rdm_chk #(
  parameter int unsigned FU_N  = rdm_pkg::DEF_FU_N,
  parameter int unsigned REG_N = rdm_pkg::DEF_REG_N,
  parameter int unsigned SRC_N = rdm_pkg::DEF_SRC_N,
  localparam int unsigned FW   = $clog2(FU_N),
  localparam int unsigned RW   = $clog2(REG_N)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      iss_valid,
  input logic [FW-1:0]             iss_fu,
  input logic                      iss_has_dst,
  input logic [RW-1:0]             iss_dst,
  input logic [SRC_N-1:0]          iss_src_vld,
  input logic [SRC_N-1:0][RW-1:0]  iss_src,
  input logic [FU_N-1:0]           rd_done,
  input logic [FU_N-1:0]           wr_done,
  input logic [FU_N-1:0][REG_N-1:0] rd_m,
  input logic [FU_N-1:0][REG_N-1:0] wr_m,
  input logic [FU_N-1:0][REG_N-1:0] lat_m,
  input logic [FU_N-1:0][FU_N-1:0] prod_vec,
  input logic [REG_N-1:0]          rd_pend
);
  logic [REG_N-1:0][FU_N-1:0] lat_col;
  always_comb begin
    for (int r = 0; r < REG_N; r++)
      for (int f = 0; f < FU_N; f++) lat_col[r][f] = lat_m[f][r];
  end

  for (genvar r = 0; r < REG_N; r++) begin : g_col
    p_lat_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lat_col[r]));
  end

  p_dst_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_has_dst |=> lat_m[$past(iss_fu)][$past(iss_dst)]);

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    p_src_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && iss_src_vld[s] |=> rd_pend[$past(iss_src[s])]);
  end

  for (genvar f = 0; f < FU_N; f++) begin : g_fu
    p_wr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done[f] && !(iss_valid && iss_fu == FW'(f))
      |=> !(|wr_m[f]) && !(|lat_m[f]));
    p_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done[f] && !(iss_valid && iss_fu == FW'(f)) |=> !(|rd_m[f]));
    p_no_self_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !prod_vec[f][f]);
    for (genvar u = 0; u < FU_N; u++) begin : g_u
      p_prod_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prod_vec[u][f] |-> (|wr_m[f]));
    end
  end
endmodule

bind regdep_matrix rdm_chk #(.FU_N(FU_N), .REG_N(REG_N), .SRC_N(SRC_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_fu     (iss_fu),
  .iss_has_dst(iss_has_dst),
  .iss_dst    (iss_dst),
  .iss_src_vld(iss_src_vld),
  .iss_src    (iss_src),
  .rd_done    (rd_done),
  .wr_done    (wr_done),
  .rd_m       (rd_m),
  .wr_m       (wr_m),
  .lat_m      (lat_m),
  .prod_vec   (prod_vec),
  .rd_pend    (rd_pend)
);

// File: tb/sim_regdep_matrix.sv
`timescale 1ns/100ps
module sim_regdep_matrix;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [2:0] iss_fu = '0;
  logic iss_has_dst = 1'b0;
  logic [4:0] iss_dst = '0;
  logic [1:0] iss_src_vld = '0;
  logic [1:0][4:0] iss_src = '0;
  logic [7:0] rd_done = '0;
  logic [7:0] wr_done = '0;
  logic [7:0][7:0] prod_vec;
  logic [31:0] rd_pend, wr_pend, rn_held;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  regdep_matrix u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_fu(iss_fu),
    .iss_has_dst(iss_has_dst), .iss_dst(iss_dst), .iss_src_vld(iss_src_vld),
    .iss_src(iss_src), .rd_done(rd_done), .wr_done(wr_done),
    .prod_vec(prod_vec), .rd_pend(rd_pend), .wr_pend(wr_pend), .rn_held(rn_held)
  );

  // entry: fu[28:26] hd[25] dst[24:20] v0[19] s0[18:14] v1[13] s1[12:8] exp[7:0]
  localparam logic [28:0] TBL [0:7] = '{
    {3'd2, 1'b1, 5'd1, 1'b1, 5'd2,  1'b1, 5'd3, 8'h00},  // R8 no holder
    {3'd0, 1'b1, 5'd4, 1'b1, 5'd1,  1'b1, 5'd3, 8'h04},  // R4 single
    {3'd1, 1'b1, 5'd1, 1'b1, 5'd5,  1'b1, 5'd6, 8'h00},  // R3 move r1
    {3'd3, 1'b1, 5'd7, 1'b1, 5'd1,  1'b1, 5'd4, 8'h03},  // R5 new writer
    {3'd4, 1'b1, 5'd8, 1'b1, 5'd1,  1'b1, 5'd1, 8'h02},  // R4 same reg twice
    {3'd5, 1'b1, 5'd9, 1'b1, 5'd9,  1'b0, 5'd0, 8'h00},  // R10 src==dst
    {3'd6, 1'b1, 5'd9, 1'b1, 5'd9,  1'b1, 5'd7, 8'h28},  // R4 two producers
    {3'd7, 1'b0, 5'd0, 1'b1, 5'd10, 1'b1, 5'd2, 8'h00}   // R8 no holders
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    iss_valid = 1'b0; iss_has_dst = 1'b0; iss_dst = '0;
    iss_src_vld = '0; iss_src = '0; rd_done = '0; wr_done = '0;
  endtask

  task automatic issue(input int fu, input bit hd, input int dst,
                       input bit v0, input int s0, input bit v1, input int s1);
    iss_valid = 1'b1; iss_fu = 3'(fu); iss_has_dst = hd; iss_dst = 5'(dst);
    iss_src_vld = {v1, v0}; iss_src[0] = 5'(s0); iss_src[1] = 5'(s1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 rd_pend", rd_pend, 32'h0);
    check("R1 wr_pend", wr_pend, 32'h0);
    check("R1 rn_held", rn_held, 32'h0);
    check("R1 prod", 32'(prod_vec[0] | prod_vec[7]), 32'h0);

    // table walk: back-to-back issues, producer row checked after each edge
    for (int i = 0; i < 8; i++) begin
      issue(int'(TBL[i][28:26]), TBL[i][25], int'(TBL[i][24:20]),
            TBL[i][19], int'(TBL[i][18:14]), TBL[i][13], int'(TBL[i][12:8]));
      tick();
      check($sformatf("R4 table entry %0d prod", i),
            32'(prod_vec[TBL[i][28:26]]), 32'(TBL[i][7:0]));
    end
    idle();
    check("R2 rd_pend after table", rd_pend, 32'h0000_06FE);
    check("R2 wr_pend after table", wr_pend, 32'h0000_0392);
    check("R3 rn_held after table", rn_held, 32'h0000_0392);

    // R7: holder of r1 (unit 1) retires; unit 2 still owes r1
    wr_done = 8'h02; tick(); idle();
    check("R7 rn_held r1 released", rn_held, 32'h0000_0390);
    check("R6 wr_pend r1 still owed", 32'(wr_pend[1]), 32'h1);
    check("R7 prod unit3 col1 cleared", 32'(prod_vec[3]), 32'h01);
    check("R7 prod unit4 col1 cleared", 32'(prod_vec[4]), 32'h00);

    // R7: superseded writer of r9 (unit 5) retires; unit 6 keeps the bit
    wr_done = 8'h20; tick(); idle();
    check("R7 rn_held r9 kept", rn_held, 32'h0000_0390);
    check("R7 wr_pend r9 kept", 32'(wr_pend[9]), 32'h1);
    check("R7 prod unit6", 32'(prod_vec[6]), 32'h08);

    // R10: holder of r4 (unit 0) retires in the cycle unit 1 reads r4
    wr_done = 8'h01;
    issue(1, 1'b1, 11, 1'b1, 4, 1'b0, 0);
    tick(); idle();
    check("R10 same-cycle retire no dep", 32'(prod_vec[1]), 32'h00);
    check("R7 prod unit3 col0 cleared", 32'(prod_vec[3]), 32'h00);
    check("R3 rn_held r4 off r11 on", rn_held, 32'h0000_0B80);
    check("R11 old reads of unit1 dropped", 32'(rd_pend[6:5]), 32'h0);
    check("R6 rd_pend r4 by unit3", 32'(rd_pend[4]), 32'h1);

    // R10: unit 5 writes r7 and reads r7, depends on unit 3
    issue(5, 1'b1, 7, 1'b1, 7, 1'b0, 0);
    tick(); idle();
    check("R10 own dst reads previous writer", 32'(prod_vec[5]), 32'h08);
    // R5: later reader of r7 depends on unit 5 only
    issue(0, 1'b0, 0, 1'b1, 7, 1'b0, 0);
    tick(); idle();
    check("R5 reader follows new writer", 32'(prod_vec[0]), 32'h20);

    // R9: unit 7 finished reading; r10 free, r2 still read by unit 2
    rd_done = 8'h80; tick(); idle();
    check("R9 rd_pend r10 cleared", 32'(rd_pend[10]), 32'h0);
    check("R9 rd_pend r2 kept", 32'(rd_pend[2]), 32'h1);

    // R1: reset in mid-run
    #1 rst_n = 1'b0;
    #1;
    check("R1 mid-run rd_pend", rd_pend, 32'h0);
    check("R1 mid-run wr_pend", wr_pend, 32'h0);
    check("R1 mid-run rn_held", rn_held, 32'h0);
    check("R1 mid-run prod", 32'(prod_vec[5] | prod_vec[0]), 32'h0);
    tick();
    rst_n = 1'b1;
    tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule